// File: doc/BRIEF.md
# Serial EEPROM Byte-Write Slave

This block is the slave side of a two-wire serial memory, covering the single-byte write transaction. It watches SCL and SDA, which reach it already synchronised to the system clock, and finds Start and Stop conditions. It then decodes a control byte and takes one address byte and one data byte, acknowledging each by pulling SDA low through an open-drain enable. The data byte is committed to a 256x8 register array on the Stop, through a one-cycle write strobe with address and data outputs.

A commit starts a timed internal write cycle. While it runs, the block flags busy and refuses every control byte. A write-protect input lets the whole command be acknowledged but suppresses the commit. The address counter steps by one after every completed byte write. A parameter can shrink the decoded address to its low bits, for smaller arrays.

The controller is a single state machine. Its states are ST_IDLE (bus free), ST_CTRL (shifting the control byte), ST_CTRL_ACK, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK (the three acknowledge slots), ST_WAIT_STOP (all three bytes taken, waiting for Stop) and ST_IGNORE (not addressed, waiting for the next Start). A Start from any state goes to ST_CTRL. A Stop from any state goes to ST_IDLE, and it commits only when it arrives in ST_WAIT_STOP. A completed byte moves ST_CTRL to ST_CTRL_ACK on a match, or to ST_IGNORE if it does not match. It moves ST_ADDR to ST_ADDR_ACK and ST_DATA to ST_DATA_ACK. An acknowledge slot is left on the SCL fall that ends the ninth clock, going to ST_ADDR, ST_DATA or ST_WAIT_STOP.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high and was high on the previous clock is a Start; a rising SDA under the same condition is a Stop; data bits are taken MSB first on each SCL rising edge.
- R2: A control byte is accepted when bits [7:4] equal 4'b1010, bits [3:1] equal `sel_strap` and bit 0 is 0 (write). An accepted byte is acknowledged: `sda_oe` rises in the cycle after the SCL fall that ends bit 8, and it drops in the cycle after the SCL fall that ends the ninth clock.
- R3: If the code or the select bits do not match, or bit 0 is 1, the slave gives no acknowledge for that byte or for any later byte until the next Start, and it writes nothing.
- R4: The address byte is acknowledged and loaded into the address counter (`mem_addr`) on the SCL fall after its bit 8. With ADDR_USED below 8, the upper bits of the counter are zero.
- R5: The data byte is acknowledged. A Stop after its acknowledge gives exactly one `mem_we` cycle, in the cycle after the Stop is seen, with `mem_addr` still holding the loaded address and `mem_wdata` holding the data byte.
- R6: `busy` is high for exactly WRITE_CYCLES clocks, starting in the same cycle as `mem_we`.
- R7: A control byte is not acknowledged if `busy` is high at the SCL fall where the byte is judged; one cycle later it is.
- R8: If `wr_protect` is high when the Stop is seen, all three bytes are still acknowledged, but neither `mem_we` nor `busy` rises, and a new command is accepted at once.
- R9: One cycle after any commit Stop, whether or not the write was protected, the address counter advances by one and wraps within the used address bits.
- R10: A Start or Stop that arrives before the data acknowledge is complete aborts with no write, and so does a Start in ST_WAIT_STOP. A Start always restarts control-byte decoding.
- R11: `sda_oe` changes only in cycles where SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (wired-AND bus level) |
| sel_strap | input | 3 | Select value the control byte must match |
| wr_protect | input | 1 | High blocks array commits |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_addr | output | 8 | Address counter, used as the array write address |
| mem_wdata | output | 8 | Data byte for the array |

## Verification
There is one cycle where two functions meet: the last cycle of the write-cycle countdown can fall on the SCL edge that judges a new control byte, and the acknowledge then depends on which of the two wins. The bench provokes this by committing a write and then sweeping the idle gap before the next Start one clock at a time, so the judging edge walks across the end of busy. Its behavioural model predicts the acknowledge per gap from its own countdown, and the bench compares this against the real `sda_oe` and bus level on every clock. It also checks that both outcomes occur, and that the first accepted gap is the predicted one.

// File: rtl/sme_pkg.sv
package sme_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int CODE_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_WAIT_STOP,
        ST_IGNORE
    } sme_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;
endpackage

// File: rtl/sme_bus_events.sv
module sme_bus_events
    import sme_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA moving while SCL stays high marks a bus condition
    always_comb begin
        evt_o.start = scl_q & scl_i & sda_q & ~sda_i;
        evt_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
        evt_o.rise  = ~scl_q & scl_i;
        evt_o.fall  = scl_q & ~scl_i;
    end
endmodule

// File: rtl/sme_byte_rx.sv
module sme_byte_rx #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] byte_o,
    output logic             full_o
);
    localparam int             CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            byte_o <= '0;
        end else if (clear_i) begin
            cnt <= '0;
        end else if (shift_i && (cnt != LAST)) begin
            byte_o <= {byte_o[WIDTH-2:0], bit_i};
            cnt    <= cnt + 1'b1;
        end
    end

    assign full_o = (cnt == LAST);

    // R1
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clear_i) |=> full_o);
endmodule

// File: rtl/sme_write_timer.sv
module sme_write_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int               CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] START = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= START;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

    // R6
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);

    // R6
    busy_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cnt) == CNT_W'(1)));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import sme_pkg::*;
#(
    parameter int                ADDR_USED    = 8,
    parameter int                WRITE_CYCLES = 5000,
    parameter logic [CODE_W-1:0] DEV_CODE     = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel_strap,
    input  logic              wr_protect,
    output logic              sda_oe,
    output logic              busy,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata
);
    localparam int ADDR_W = BYTE_W;

    bus_evt_t          evt;
    sme_state_e        state;
    sme_state_e        nxt;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              receiving;
    logic              in_ack;
    logic              byte_done;
    logic              rx_clear;
    logic              ctrl_hit;
    logic              commit;
    logic              ack_clk_q;
    logic              we_q;
    logic              adv_q;
    logic [ADDR_W-1:0] addr_cnt;
    logic [ADDR_W-1:0] load_val;
    logic [ADDR_W-1:0] inc_val;
    logic [BYTE_W-1:0] data_q;

    sme_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    sme_byte_rx #(.WIDTH(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rx_clear),
        .shift_i (receiving & evt.rise),
        .bit_i   (sda_i),
        .byte_o  (rx_byte),
        .full_o  (rx_full)
    );

    sme_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (commit & ~wr_protect),
        .busy_o (busy)
    );

    // Address width variant: narrow arrays keep only the low bits
    generate
        if (ADDR_USED < ADDR_W) begin : g_narrow
            assign load_val = {{(ADDR_W-ADDR_USED){1'b0}}, rx_byte[ADDR_USED-1:0]};
            assign inc_val  = {{(ADDR_W-ADDR_USED){1'b0}}, addr_cnt[ADDR_USED-1:0] + 1'b1};
        end else begin : g_full
            assign load_val = rx_byte;
            assign inc_val  = addr_cnt + 1'b1;
        end
    endgenerate

    always_comb begin
        receiving = (state == ST_CTRL) || (state == ST_ADDR) || (state == ST_DATA);
        in_ack    = (state == ST_CTRL_ACK) || (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
        byte_done = receiving & evt.fall & rx_full;
        rx_clear  = ~receiving | byte_done | evt.start | evt.stop;
        ctrl_hit  = (rx_byte[BYTE_W-1 -: CODE_W] == DEV_CODE)
                  && (rx_byte[SEL_W:1] == sel_strap)
                  && !rx_byte[0]
                  && !busy;
        commit    = evt.stop && (state == ST_WAIT_STOP);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (evt.start) begin
            nxt = ST_CTRL;
        end else if (evt.stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE, ST_WAIT_STOP: nxt = state;
                ST_CTRL:     if (byte_done) nxt = ctrl_hit ? ST_CTRL_ACK : ST_IGNORE;
                ST_ADDR:     if (byte_done) nxt = ST_ADDR_ACK;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_CTRL_ACK: if (evt.fall && ack_clk_q) nxt = ST_ADDR;
                ST_ADDR_ACK: if (evt.fall && ack_clk_q) nxt = ST_DATA;
                ST_DATA_ACK: if (evt.fall && ack_clk_q) nxt = ST_WAIT_STOP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_clk_q <= 1'b0;
            we_q      <= 1'b0;
            adv_q     <= 1'b0;
            addr_cnt  <= '0;
            data_q    <= '0;
        end else begin
            if (nxt != state) begin
                ack_clk_q <= 1'b0;
            end else if (in_ack && evt.rise) begin
                ack_clk_q <= 1'b1;
            end
            we_q  <= commit & ~wr_protect;
            adv_q <= commit;
            if ((state == ST_ADDR) && byte_done) begin
                addr_cnt <= load_val;
            end else if (adv_q) begin
                addr_cnt <= inc_val;
            end
            if ((state == ST_DATA) && byte_done) begin
                data_q <= rx_byte;
            end
        end
    end

    // Output logic
    always_comb begin
        unique case (state)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign mem_we    = we_q;
    assign mem_addr  = addr_cnt;
    assign mem_wdata = data_q;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R7
    ctrl_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && (state == ST_CTRL_ACK)) |-> !$past(busy));

    // R5
    we_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(busy));

    // R8
    we_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wr_protect));

    // R9
    addr_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !$stable(mem_addr));
endmodule

// File: tb/serial_mem_slave_bench.sv
module serial_mem_slave_bench;
    localparam int WCYC = 300;
    localparam logic [7:0] CTRL_W = 8'hAA;  // 1010, select 101, write

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0;
    logic       sda_bus;

    logic       oe_f, busy_f, we_f;
    logic [7:0] addr_f, wd_f;
    logic       oe_n, busy_n, we_n;
    logic [7:0] addr_n, wd_n;

    assign sda_bus = sda_m & ~oe_f & ~oe_n;

    serial_mem_slave #(.ADDR_USED(8), .WRITE_CYCLES(WCYC)) u_serial_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_strap(strap),
        .wr_protect(wp), .sda_oe(oe_f), .busy(busy_f), .mem_we(we_f),
        .mem_addr(addr_f), .mem_wdata(wd_f));

    serial_mem_slave #(.ADDR_USED(4), .WRITE_CYCLES(WCYC)) u_serial_mem_slave_narrow (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_strap(strap),
        .wr_protect(wp), .sda_oe(oe_n), .busy(busy_n), .mem_we(we_n),
        .mem_addr(addr_n), .mem_wdata(wd_n));

    // Behavioural model state
    int         m_busy = 0;
    bit         m_we = 0;
    bit         m_adv = 0;
    bit         m_oe = 0;
    bit         sched_commit = 0;
    bit         decide_ctrl = 0;
    bit         ctrl_ok = 0;
    logic [7:0] cur_ctrl = '0;
    logic [7:0] m_addr_f = '0;
    logic [7:0] m_addr_n = '0;
    logic [7:0] m_wdata = '0;
    logic       prev_oe = 1'b0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock: the model predicts the state after the coming edge,
    // then everything is compared at the following falling edge.
    task automatic tick();
        logic scl_edge;
        scl_edge = scl;
        m_we = 0;
        if (m_adv) begin
            m_addr_f = m_addr_f + 8'd1;
            m_addr_n = (m_addr_n + 8'd1) & 8'h0F;
            m_adv = 0;
        end
        if (decide_ctrl) begin
            ctrl_ok = (cur_ctrl[7:4] == 4'b1010) && (cur_ctrl[3:1] == strap)
                      && !cur_ctrl[0] && (m_busy == 0);
            m_oe = ctrl_ok;
            decide_ctrl = 0;
        end
        if (m_busy > 0) m_busy--;
        if (sched_commit) begin
            sched_commit = 0;
            m_adv = 1;
            if (!wp) begin
                m_we = 1;
                m_busy = WCYC;
            end
        end
        @(negedge clk);
        chk(oe_f == m_oe, "R2 sda_oe full", int'(oe_f), int'(m_oe));
        chk(oe_n == m_oe, "R2 sda_oe narrow", int'(oe_n), int'(m_oe));
        chk(we_f == m_we, "R5 mem_we full", int'(we_f), int'(m_we));
        chk(we_n == m_we, "R5 mem_we narrow", int'(we_n), int'(m_we));
        chk(busy_f == (m_busy > 0), "R6 busy full", int'(busy_f), int'(m_busy > 0));
        chk(busy_n == (m_busy > 0), "R6 busy narrow", int'(busy_n), int'(m_busy > 0));
        chk(addr_f == m_addr_f, "R9 addr full", int'(addr_f), int'(m_addr_f));
        chk(addr_n == m_addr_n, "R4 addr narrow", int'(addr_n), int'(m_addr_n));
        if (m_we) begin
            chk(wd_f == m_wdata, "R5 wdata full", int'(wd_f), int'(m_wdata));
            chk(wd_n == m_wdata, "R5 wdata narrow", int'(wd_n), int'(m_wdata));
        end
        chk(!(oe_f != prev_oe && scl_edge), "R11 oe moved with SCL high", int'(oe_f), int'(prev_oe));
        prev_oe = oe_f;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_start();
        sda_m = 1'b1; ticks(2);
        scl = 1'b1;   ticks(2);
        sda_m = 1'b0; ticks(2);
        scl = 1'b0;   ticks(2);
    endtask

    task automatic do_stop(input bit commit_here);
        sda_m = 1'b0; ticks(2);
        scl = 1'b1;   ticks(2);
        sda_m = 1'b1; sched_commit = commit_here; ticks(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; ticks(2);
            scl = 1'b1;   ticks(2);
            scl = 1'b0;   ticks(2);
        end
    endtask

    // kind: 0 control, 1 address, 2 data; acc: slave is taking this byte
    task automatic send_byte(input logic [7:0] b, input int kind, input bit acc, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; ticks(2);
            scl = 1'b1;   ticks(2);
            scl = 1'b0;
            if (i == 0) begin
                if (kind == 0) begin
                    cur_ctrl = b;
                    decide_ctrl = 1;
                end else begin
                    m_oe = acc;
                    if (acc && kind == 1) begin
                        m_addr_f = b;
                        m_addr_n = b & 8'h0F;
                    end
                    if (acc && kind == 2) m_wdata = b;
                end
            end
            ticks(2);
        end
        sda_m = 1'b1; ticks(2);
        scl = 1'b1;   tick();
        acked = m_oe;
        chk((sda_bus == 1'b0) == m_oe, "R2 bus ack level", int'(sda_bus), int'(!m_oe));
        tick();
        scl = 1'b0; m_oe = 0; ticks(2);
    endtask

    task automatic write_txn(input logic [7:0] ctrl, input logic [7:0] a,
                             input logic [7:0] d, output bit c);
        bit x, y;
        do_start();
        send_byte(ctrl, 0, 0, c);
        send_byte(a, 1, c, x);
        send_byte(d, 2, x, y);
        do_stop(c && x && y);
    endtask

    task automatic wait_idle();
        while (m_busy > 0) tick();
        ticks(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit a, b, c;
        bit saw_acc, saw_rej;
        int first_acc;
        ticks(3);
        rst_n = 1'b1;
        ticks(3);  // reset state compared inside tick

        // R2 R4 R5 R6 R9: plain write
        write_txn(CTRL_W, 8'h3A, 8'h5C, a);
        chk(a, "R2 control accepted", int'(a), 1);
        ticks(4);
        wait_idle();

        // R4 R9: wrap of the counter in both address widths
        write_txn(CTRL_W, 8'hFF, 8'h11, a);
        wait_idle();

        // R8: protected write, then an immediate unprotected one
        wp = 1'b1;
        write_txn(CTRL_W, 8'h20, 8'h77, a);
        chk(a, "R8 protected command acked", int'(a), 1);
        ticks(2);
        wp = 1'b0;
        write_txn(CTRL_W, 8'h40, 8'h99, a);
        chk(a, "R8 next command accepted at once", int'(a), 1);

        // R7: control byte during the write cycle is refused
        do_start();
        send_byte(CTRL_W, 0, 0, a);
        chk(!a, "R7 refused while busy", int'(a), 0);
        send_byte(8'h12, 1, 0, b);
        chk(!b, "R3 later byte ignored", int'(b), 0);
        do_stop(0);
        wait_idle();

        // R3: wrong code, wrong select, read request
        do_start(); send_byte(8'hBA, 0, 0, a); chk(!a, "R3 code mismatch", int'(a), 0); do_stop(0);
        do_start(); send_byte(8'hA4, 0, 0, a); chk(!a, "R3 select mismatch", int'(a), 0);
        send_byte(8'h55, 1, 0, b); send_byte(8'h66, 2, 0, c);
        chk(!b && !c, "R3 following bytes ignored", int'(b | c), 0);
        do_stop(0);
        do_start(); send_byte(8'hAB, 0, 0, a); chk(!a, "R3 read refused", int'(a), 0); do_stop(0);

        // R10: Stop inside the data byte
        do_start(); send_byte(CTRL_W, 0, 0, a); send_byte(8'h10, 1, a, b);
        send_bits(8'hF0, 3);
        do_stop(0);
        // R10: repeated Start inside the data byte, then a full write
        do_start(); send_byte(CTRL_W, 0, 0, a); send_byte(8'h05, 1, a, b);
        send_bits(8'h0F, 4);
        do_start();
        send_byte(CTRL_W, 0, 0, a); send_byte(8'h06, 1, a, b); send_byte(8'h42, 2, b, c);
        chk(a && b && c, "R10 restart decodes control", int'(a && b && c), 1);
        do_stop(1);
        wait_idle();
        // R10: Start after the data acknowledge drops the write
        do_start(); send_byte(CTRL_W, 0, 0, a); send_byte(8'h07, 1, a, b); send_byte(8'h33, 2, b, c);
        do_start();
        do_stop(0);
        ticks(4);

        // R7: sweep the judging edge across the end of busy
        saw_acc = 0; saw_rej = 0; first_acc = -1;
        for (int g = WCYC - 70; g <= WCYC - 45; g++) begin
            wait_idle();
            write_txn(CTRL_W, 8'h60, 8'h0F, a);
            ticks(g);
            do_start();
            send_byte(CTRL_W, 0, 0, a);
            if (a) begin
                saw_acc = 1;
                if (first_acc < 0) first_acc = g;
            end else begin
                saw_rej = 1;
            end
            do_stop(0);
        end
        chk(saw_acc && saw_rej, "R7 both outcomes in sweep", int'({saw_acc, saw_rej}), 3);
        chk(first_acc == WCYC - 55, "R7 first accepted gap", first_acc, WCYC - 55);
        wait_idle();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule